// File: doc/BRIEF.md
# Subranging Flash Conversion Sequencer

This block is the timing controller for one conversion of a four-step subranging converter. A system clock runs it. A rising edge on the encode input starts a conversion. The block then raises four one-cycle strobes, in a fixed order: the first flash, the second flash, the coarse back-end flash and the fine back-end flash. It leaves a programmable gap between the first two strobes. It leaves a longer settle interval after the second strobe, so the residue amplifier can settle before the back-end steps. A third gap sits between the two back-end strobes. Every analog delay is modelled as a cycle count set by a parameter.

After the fine strobe, the block asserts a one-cycle load enable. In that cycle the converted word and its out-of-range bit are copied into the output register. The data-available output rises only after one full cycle of setup, so the data is valid before that edge. The output register holds its value while data-available is high, and it changes only at a later load. The block also watches the encode input. A rising edge that arrives during a conversion does not start anything, and a flag pulses to report it. If encode falls after the permitted window but before the conversion has finished, a width-error flag pulses.

Top module: `flash_conv_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all strobes, `load_o`, `dav_o`, `overlap_o` and `width_err_o` are low, and `data_o` and `otr_o` are zero.
- R2: If `encode_i` is sampled high at an edge, was sampled low at the edge before, and the block is idle, then `strobe_o[0]` (first flash) is high for exactly the one cycle after that edge.
- R3: The strobes come in the order bit 0, bit 1, bit 2, bit 3. Each lasts one cycle. Bit 1 rises GAP_A+1 cycles after bit 0. Bit 2 rises SETTLE+1 cycles after bit 1. Bit 3 rises GAP_B+1 cycles after bit 2. At most one of the strobes, `load_o` and `dav_o` is high in any cycle.
- R4: `load_o` is high for the single cycle right after the bit-3 strobe. At the end of that cycle, `data_o` and `otr_o` take the values of `conv_data_i` and `conv_otr_i`.
- R5: `dav_o` rises two cycles after `load_o` rises, which leaves one full cycle in which the new data is already present. It then stays high for DAV_CYC cycles.
- R6: `data_o` and `otr_o` change only at the end of a load cycle. They are therefore stable while `dav_o` is high, and until the next conversion loads.
- R7: Only a low-to-high change of `encode_i` starts a conversion. Holding encode high past the end of a conversion does not start another one.
- R8: A rising edge of `encode_i` sampled while a conversion is in progress (from the first strobe through the last `dav_o` cycle) is ignored. `overlap_o` is high for the one cycle after that edge.
- R9: A falling edge of `encode_i` sampled within WIN edges after the start edge is accepted. A falling edge sampled later, while the conversion is still in progress, makes `width_err_o` high for the one cycle after it. A falling edge while idle raises nothing.
- R10: A new conversion may start at the first edge after `dav_o` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| encode_i | input | 1 | Conversion start; a rising edge starts a conversion |
| conv_data_i | input | DW | Converted word presented to the result register |
| conv_otr_i | input | 1 | Out-of-range bit presented with the word |
| strobe_o | output | 4 | Flash strobes: bit 0 first, 1 second, 2 coarse back-end, 3 fine back-end |
| load_o | output | 1 | Result register load enable |
| dav_o | output | 1 | Data available; high after the data is valid |
| data_o | output | DW | Registered conversion result |
| otr_o | output | 1 | Registered out-of-range bit |
| overlap_o | output | 1 | One-cycle pulse: an encode rising edge was ignored |
| width_err_o | output | 1 | One-cycle pulse: encode fell outside its permitted window |

## Verification
The bench builds the block with WIN=3, GAP_A=2, SETTLE=6, GAP_B=1 and DAV_CYC=4, so one conversion takes 19 cycles. Because conversions are this short, a single run holds hundreds of starts, and randomly timed encode edges land in every phase, the data-available phase included. GAP_B=1 exercises the shortest allowed gap between the back-end strobes. With WIN=3, encode pulses can be placed just inside the window and just outside it. The converted word changes on every cycle, so a load taken one cycle early or late shows up as a mismatch.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CNT_W   = 16;
    localparam int NUM_STB = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FL1,
        ST_GAPA,
        ST_FL2,
        ST_SETTLE,
        ST_FL3,
        ST_GAPB,
        ST_FL4,
        ST_LOAD,
        ST_SETUP,
        ST_DAV
    } seq_state_e;

    typedef struct packed {
        seq_state_e         state;
        logic [CNT_W-1:0]   cnt;
    } ctrl_regs_t;

    typedef struct packed {
        logic [CNT_W-1:0]   win;
        logic               ovl;
        logic               werr;
    } guard_regs_t;

    function automatic seq_state_e strobe_state(input int idx);
        case (idx)
            0:       strobe_state = ST_FL1;
            1:       strobe_state = ST_FL2;
            2:       strobe_state = ST_FL3;
            default: strobe_state = ST_FL4;
        endcase
    endfunction

endpackage

// File: rtl/fcs_edge.sv
module fcs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_i,
    output logic rise_o,
    output logic fall_o
);
    logic enc_d, enc_q;

    always_comb begin
        enc_d = enc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= 1'b0;
        else        enc_q <= enc_d;
    end

    assign rise_o = enc_i & ~enc_q;
    assign fall_o = ~enc_i & enc_q;
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int GAP_A   = 2,
    parameter int SETTLE  = 8,
    parameter int GAP_B   = 2,
    parameter int DAV_CYC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    output logic               busy_o,
    output logic [NUM_STB-1:0] strobe_o,
    output logic               load_o,
    output logic               dav_o
);
    localparam logic [CNT_W-1:0] GA_LD = CNT_W'(GAP_A - 1);
    localparam logic [CNT_W-1:0] ST_LD = CNT_W'(SETTLE - 1);
    localparam logic [CNT_W-1:0] GB_LD = CNT_W'(GAP_B - 1);
    localparam logic [CNT_W-1:0] DV_LD = CNT_W'(DAV_CYC - 1);

    ctrl_regs_t r_d, r_q;
    logic       cnt_done;

    assign cnt_done = (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (!cnt_done) r_d.cnt = r_q.cnt - 1'b1;
        case (r_q.state)
            ST_IDLE:   if (rise_i) r_d.state = ST_FL1;
            ST_FL1:    begin r_d.state = ST_GAPA;   r_d.cnt = GA_LD; end
            ST_GAPA:   if (cnt_done) r_d.state = ST_FL2;
            ST_FL2:    begin r_d.state = ST_SETTLE; r_d.cnt = ST_LD; end
            ST_SETTLE: if (cnt_done) r_d.state = ST_FL3;
            ST_FL3:    begin r_d.state = ST_GAPB;   r_d.cnt = GB_LD; end
            ST_GAPB:   if (cnt_done) r_d.state = ST_FL4;
            ST_FL4:    r_d.state = ST_LOAD;
            ST_LOAD:   r_d.state = ST_SETUP;
            ST_SETUP:  begin r_d.state = ST_DAV;    r_d.cnt = DV_LD; end
            ST_DAV:    if (cnt_done) r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        assign strobe_o[i] = (r_q.state == strobe_state(i));
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign load_o = (r_q.state == ST_LOAD);
    assign dav_o  = (r_q.state == ST_DAV);

    // R2
    first_from_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o[0] |-> $past(rise_i));
    // R3
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe_o, load_o, dav_o}));
    // R4
    fine_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o[NUM_STB-1] |=> load_o);
    // R5
    dav_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_o) |-> $past(load_o, 2));
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
    import fcs_pkg::*;
#(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic busy_i,
    output logic overlap_o,
    output logic width_err_o
);
    localparam logic [CNT_W-1:0] WIN_LD = CNT_W'(WIN);

    guard_regs_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.ovl  = rise_i & busy_i;
        g_d.werr = fall_i & busy_i & (g_q.win == '0);
        if (rise_i && !busy_i)  g_d.win = WIN_LD;
        else if (g_q.win != '0) g_d.win = g_q.win - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.win  <= '0;
            g_q.ovl  <= 1'b0;
            g_q.werr <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign overlap_o   = g_q.ovl;
    assign width_err_o = g_q.werr;

    // R8
    overlap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> $past(busy_i));
    // R9
    werr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        width_err_o |-> ($past(fall_i) && $past(busy_i)));
endmodule

// File: rtl/fcs_result.sv
module fcs_result #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          dav_i,
    input  logic [DW-1:0] data_i,
    input  logic          otr_i,
    output logic [DW-1:0] data_o,
    output logic          otr_o
);
    logic [DW-1:0] data_d, data_q;
    logic          otr_d, otr_q;

    always_comb begin
        data_d = data_q;
        otr_d  = otr_q;
        if (load_i) begin
            data_d = data_i;
            otr_d  = otr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            otr_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            otr_q  <= otr_d;
        end
    end

    assign data_o = data_q;
    assign otr_o  = otr_q;

    // R6
    hold_during_dav_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_i && $past(dav_i)) |-> ($stable(data_q) && $stable(otr_q)));
endmodule

// File: rtl/flash_conv_seq.sv
module flash_conv_seq
    import fcs_pkg::*;
#(
    parameter int DW      = 12,
    parameter int WIN     = 3,
    parameter int GAP_A   = 2,
    parameter int SETTLE  = 8,
    parameter int GAP_B   = 2,
    parameter int DAV_CYC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               encode_i,
    input  logic [DW-1:0]      conv_data_i,
    input  logic               conv_otr_i,
    output logic [NUM_STB-1:0] strobe_o,
    output logic               load_o,
    output logic               dav_o,
    output logic [DW-1:0]      data_o,
    output logic               otr_o,
    output logic               overlap_o,
    output logic               width_err_o
);
    logic rise, fall, busy;

    fcs_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .enc_i  (encode_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    fcs_ctrl #(
        .GAP_A   (GAP_A),
        .SETTLE  (SETTLE),
        .GAP_B   (GAP_B),
        .DAV_CYC (DAV_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .busy_o   (busy),
        .strobe_o (strobe_o),
        .load_o   (load_o),
        .dav_o    (dav_o)
    );

    fcs_guard #(
        .WIN (WIN)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .busy_i      (busy),
        .overlap_o   (overlap_o),
        .width_err_o (width_err_o)
    );

    fcs_result #(
        .DW (DW)
    ) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_o),
        .dav_i  (dav_o),
        .data_i (conv_data_i),
        .otr_i  (conv_otr_i),
        .data_o (data_o),
        .otr_o  (otr_o)
    );
endmodule

// File: tb/flash_conv_seq_bench.sv
module flash_conv_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW      = 12;
    localparam int WIN     = 3;
    localparam int GAP_A   = 2;
    localparam int SETTLE  = 6;
    localparam int GAP_B   = 1;
    localparam int DAV_CYC = 4;
    localparam int T_S1    = GAP_A + 1;
    localparam int T_S2    = GAP_A + SETTLE + 2;
    localparam int T_S3    = GAP_A + SETTLE + GAP_B + 3;
    localparam int T_LOAD  = GAP_A + SETTLE + GAP_B + 4;
    localparam int T_DAV0  = T_LOAD + 2;
    localparam int T_DAV1  = T_LOAD + 1 + DAV_CYC;
    localparam int T_END   = T_LOAD + 2 + DAV_CYC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          encode = 1'b0;
    logic [DW-1:0] din = '0;
    logic          otr_in = 1'b0;
    logic [3:0]    strobe;
    logic          load, dav, otr_out, ovl, werr;
    logic [DW-1:0] dout;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_conv_seq #(
        .DW(DW), .WIN(WIN), .GAP_A(GAP_A), .SETTLE(SETTLE),
        .GAP_B(GAP_B), .DAV_CYC(DAV_CYC)
    ) u_flash_conv_seq (
        .clk(clk), .rst_n(rst_n), .encode_i(encode),
        .conv_data_i(din), .conv_otr_i(otr_in),
        .strobe_o(strobe), .load_o(load), .dav_o(dav),
        .data_o(dout), .otr_o(otr_out),
        .overlap_o(ovl), .width_err_o(werr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // behavioural reference: time since start of the running conversion
    bit            m_busy = 1'b0;
    int            m_t    = 0;
    bit            m_prev = 1'b0;
    int            m_win  = 0;
    bit            m_ovl  = 1'b0;
    bit            m_werr = 1'b0;
    bit            m_rise, m_fall;
    logic [DW-1:0] m_res = '0;
    bit            m_otr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_prev = 0; m_win = 0;
            m_ovl = 0; m_werr = 0; m_res = '0; m_otr = 0;
        end else begin
            m_rise = encode && !m_prev;
            m_fall = !encode && m_prev;
            m_ovl  = m_rise && m_busy;
            m_werr = m_fall && m_busy && (m_win == 0);
            if (m_busy && m_t == T_LOAD) begin
                m_res = din;
                m_otr = otr_in;
            end
            if (m_rise && !m_busy) m_win = WIN;
            else if (m_win > 0)    m_win--;
            if (m_busy) begin
                m_t++;
                if (m_t == T_END) m_busy = 0;
            end else if (m_rise) begin
                m_busy = 1;
                m_t    = 0;
            end
            m_prev = encode;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e_stb;
            e_stb[0] = m_busy && m_t == 0;
            e_stb[1] = m_busy && m_t == T_S1;
            e_stb[2] = m_busy && m_t == T_S2;
            e_stb[3] = m_busy && m_t == T_S3;
            check(strobe == e_stb, "R3 strobe order", strobe, e_stb);
            check(load == (m_busy && m_t == T_LOAD), "R4 load cycle", load, m_busy && m_t == T_LOAD);
            check(dav == (m_busy && m_t >= T_DAV0 && m_t <= T_DAV1), "R5 dav window",
                  dav, m_busy && m_t >= T_DAV0 && m_t <= T_DAV1);
            check(dout == m_res && otr_out == m_otr, "R6 result hold",
                  {otr_out, dout}, {m_otr, m_res});
            check(ovl == m_ovl, "R8 overlap flag", ovl, m_ovl);
            check(werr == m_werr, "R9 width error", werr, m_werr);
        end
    end

    always @(posedge clk) begin
        #2;
        din    <= DW'($urandom);
        otr_in <= 1'($urandom);
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(strobe == 0 && !load && !dav && !ovl && !werr && dout == 0 && !otr_out,
              "R1 reset state", {strobe, load, dav, ovl, werr, otr_out}, 0);
        cyc(1);

        // R2: single short pulse
        encode = 1'b1; cyc(1); encode = 1'b0;
        @(negedge clk);
        check(strobe == 4'b0001, "R2 first strobe after rise", strobe, 1);
        cyc(25);

        // R9: fall on the last edge inside the window
        encode = 1'b1; cyc(WIN); encode = 1'b0; cyc(25);

        // R9: fall past the window while busy
        encode = 1'b1; cyc(WIN + 3); encode = 1'b0; cyc(25);

        // R7: level held high past the conversion
        encode = 1'b1; cyc(40);
        @(negedge clk);
        check(!dav && strobe == 0, "R7 no retrigger on level", {dav, strobe}, 0);
        cyc(1);
        encode = 1'b0; cyc(3);

        // R8: rises in the middle and during data-available
        encode = 1'b1; cyc(1); encode = 1'b0; cyc(4);
        encode = 1'b1; cyc(1); encode = 1'b0; cyc(10);
        encode = 1'b1; cyc(2); encode = 1'b0; cyc(25);

        // R10: restart at first idle cycle after dav falls
        encode = 1'b1; cyc(1); encode = 1'b0;
        do @(negedge clk); while (!dav);
        do @(negedge clk); while (dav);
        #1 encode = 1'b1;
        @(posedge clk); #2 encode = 1'b0;
        @(negedge clk);
        check(strobe == 4'b0001, "R10 back-to-back start", strobe, 1);
        cyc(25);

        // random encode activity across all phases
        repeat (400) begin
            encode = 1'($urandom);
            cyc(1 + ($urandom % 4));
        end
        encode = 1'b0;
        cyc(30);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            finish_run();
        end
    end
endmodule